// File: doc/BRIEF.md
# Supply Monitor with Timed Reset and Write Protect

This block turns three digitized supply comparator flags into the control signals a battery-backed memory needs. The flags report whether the supply is above the tolerance threshold, above the lower protect threshold, and above the still lower switchover level. From these the block produces an active-low system reset, a write-protect signal for the memory array and a select line that moves the array onto its backup energy source.

If the supply leaves tolerance, reset and write protect assert so that the processor is warned before power is lost. Below the switchover level the backup source is selected. When the supply comes back above the switchover level the external supply is selected again. Once the supply is back in tolerance, reset and write protect stay asserted for a programmable number of clock cycles. The nominal setting is 200 ms. The count starts over if the supply dips out of tolerance before it completes.

The flags arrive from analog comparators and are resynchronized inside the block. Because the thresholds are nested, a flag for a lower threshold that reads low overrides any flag above it that reads high.

Top module: `supply_monitor`

## Requirements
- R1: While rst_ni is low, rst_no is 0, wp_o is 1 and bkup_sel_o is 1.
- R2: With the default two synchronizer stages, rst_no falls on the third rising clock edge after the tolerance flag goes low. Edges are counted from the first edge that samples the low value.
- R3: After all three flags become high and stay high, rst_no rises on exactly edge HOLD_CYCLES+2, counted from the first edge that samples them high.
- R4: If the tolerance flag is sampled low on even one edge before the hold completes, the hold restarts. rst_no then rises HOLD_CYCLES+2 edges after the flags are seen high again.
- R5: wp_o is 1 whenever rst_no is 0.
- R6: When the protect flag goes low, wp_o reaches 1 by the third edge. It stays 1 until the next release of rst_no.
- R7: bkup_sel_o equals the inverse of the switchover flag, delayed by three edges. It does not depend on the tolerance flag, the protect flag or the hold state.
- R8: The thresholds are ordered: switchover < protect < tolerance. A low protect flag counts as out of tolerance. A low switchover flag counts as below both higher thresholds. Either case holds rst_no at 0 and wp_o at 1, even when a higher flag reads high.
- R9: Once released, rst_no stays 1 for as long as all three flags stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tol_ok_i | input | 1 | Supply above tolerance threshold (asynchronous) |
| prot_ok_i | input | 1 | Supply above protect threshold (asynchronous) |
| sw_ok_i | input | 1 | Supply above switchover level (asynchronous) |
| rst_no | output | 1 | Active-low system reset |
| wp_o | output | 1 | Memory write protect, active high |
| bkup_sel_o | output | 1 | 1 selects the backup source for the memory |

## Verification
A corrupted hold counter shows up at rst_no as a release that comes early or late. A test that measures the exact edge of release catches it, and so does a test that dips the supply partway through the hold. A stuck done flag shows up within three edges of a supply drop, because rst_no fails to fall. A wrong level ordering shows up as a released reset, or as a deasserted write protect, while only a lower flag is low. A wrong backup select shows up three edges after the switchover flag changes.

// File: rtl/smon_pkg.sv
package smon_pkg;
  typedef struct packed {
    logic tol;
    logic prot;
    logic sw;
  } lvl_t;

  localparam int unsigned LVL_W = $bits(lvl_t);

  // lower thresholds dominate: a low lower flag clears every flag above it
  function automatic lvl_t order_levels(lvl_t raw);
    lvl_t o;
    o.sw   = raw.sw;
    o.prot = raw.prot & raw.sw;
    o.tol  = raw.tol & raw.prot & raw.sw;
    return o;
  endfunction
endpackage

// File: rtl/smon_sync.sv
module smon_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/smon_hold_timer.sv
module smon_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ok_i,
  output logic done_o
);
  localparam int unsigned CNT_W = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!ok_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/smon_out_ctrl.sv
module smon_out_ctrl
  import smon_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  lvl_t lvl_i,
  input  logic hold_done_i,
  output logic wp_o,
  output logic bkup_sel_o
);
  logic prot_low_q;
  logic bkup_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_low_q <= 1'b1;
      bkup_q     <= 1'b1;
    end else begin
      prot_low_q <= ~lvl_i.prot;
      bkup_q     <= ~lvl_i.sw;
    end
  end

  assign wp_o       = prot_low_q | ~hold_done_i;
  assign bkup_sel_o = bkup_q;
endmodule

// File: rtl/supply_monitor.sv
module supply_monitor
  import smon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYCLES = 40_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tol_ok_i,
  input  logic prot_ok_i,
  input  logic sw_ok_i,
  output logic rst_no,
  output logic wp_o,
  output logic bkup_sel_o
);
  lvl_t raw_lvl, sync_lvl, ord_lvl;
  logic hold_done;

  assign raw_lvl = '{tol: tol_ok_i, prot: prot_ok_i, sw: sw_ok_i};

  smon_sync #(.WIDTH(LVL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_lvl),
    .q_o   (sync_lvl)
  );

  assign ord_lvl = order_levels(sync_lvl);

  smon_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ok_i  (ord_lvl.tol),
    .done_o(hold_done)
  );

  smon_out_ctrl u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lvl_i      (ord_lvl),
    .hold_done_i(hold_done),
    .wp_o       (wp_o),
    .bkup_sel_o (bkup_sel_o)
  );

  assign rst_no = hold_done;
endmodule

// File: rtl/supply_monitor_chk.sv
module supply_monitor_chk #(
  parameter int unsigned HOLD_CYCLES = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tol_ok_i,
  input logic prot_ok_i,
  input logic sw_ok_i,
  input logic rst_no,
  input logic wp_o,
  input logic bkup_sel_o
);
  logic        all_ok;
  logic [31:0] ok_run_q;

  assign all_ok = tol_ok_i & prot_ok_i & sw_ok_i;

  // consecutive sampled edges with every flag high, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ok_run_q <= '0;
    else if (!all_ok)             ok_run_q <= '0;
    else if (ok_run_q != '1)      ok_run_q <= ok_run_q + 1'b1;
  end

  p_wp_with_rst_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_no |-> wp_o);

  p_bkup_holds_rst_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bkup_sel_o |-> !rst_no);

  p_release_after_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> (ok_run_q >= 32'(HOLD_CYCLES)));

  p_no_drop_while_ok_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_no) |-> (ok_run_q < 32'd3));

  p_bkup_on_low_sw_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bkup_sel_o) |-> !$past(sw_ok_i, 2));

  p_bkup_off_high_sw_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bkup_sel_o) |-> $past(sw_ok_i, 2));
endmodule

bind supply_monitor supply_monitor_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tol_ok_i  (tol_ok_i),
  .prot_ok_i (prot_ok_i),
  .sw_ok_i   (sw_ok_i),
  .rst_no    (rst_no),
  .wp_o      (wp_o),
  .bkup_sel_o(bkup_sel_o)
);

// File: tb/tb_supply_monitor.sv
`timescale 1ns/1ps
module tb_supply_monitor;
  localparam int unsigned HOLD = 16;
  localparam int unsigned NVEC = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tol = 1'b0, prot = 1'b0, sw = 1'b0;
  logic rst_no, wp, bkup;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  supply_monitor #(.SYNC_STAGES(2), .HOLD_CYCLES(HOLD)) dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tol_ok_i  (tol),
    .prot_ok_i (prot),
    .sw_ok_i   (sw),
    .rst_no    (rst_no),
    .wp_o      (wp),
    .bkup_sel_o(bkup)
  );

  // flags are {tol, prot, sw}
  typedef struct packed {
    logic [2:0]  flags;
    logic [7:0]  wait_n;
    logic        e_rst;
    logic        e_wp;
    logic        e_bkup;
    logic [15:0] tag;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{3'b000, 8'd30, 1'b0, 1'b1, 1'b1, "R7"},  // nothing up: backup
    '{3'b001, 8'd30, 1'b0, 1'b1, 1'b0, "R7"},  // above switchover only
    '{3'b011, 8'd30, 1'b0, 1'b1, 1'b0, "R6"},  // protect band
    '{3'b111, 8'd30, 1'b1, 1'b0, 1'b0, "R3"},  // full tolerance
    '{3'b101, 8'd30, 1'b0, 1'b1, 1'b0, "R8"},  // protect low overrides tol
    '{3'b111, 8'd30, 1'b1, 1'b0, 1'b0, "R3"},
    '{3'b110, 8'd30, 1'b0, 1'b1, 1'b1, "R8"},  // switchover low overrides all
    '{3'b111, 8'd30, 1'b1, 1'b0, 1'b0, "R9"},
    '{3'b011, 8'd5,  1'b0, 1'b1, 1'b0, "R2"},
    '{3'b111, 8'd30, 1'b1, 1'b0, 1'b0, "R9"}
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_flags(input logic [2:0] f);
    {tol, prot, sw} = f;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    tick(3);
    chk("R1", "rst_no", rst_no, 1'b0);
    chk("R1", "wp", wp, 1'b1);
    chk("R1", "bkup", bkup, 1'b1);
    set_flags(3'b111);
    tick(3);
    chk("R1", "rst_no held", rst_no, 1'b0);
    chk("R1", "bkup held", bkup, 1'b1);
    set_flags(3'b000);
    rst_n = 1'b1;
    tick(10);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      set_flags(VECS[i].flags);
      tick(int'(VECS[i].wait_n));
      chk(string'(VECS[i].tag), "rst_no", rst_no, VECS[i].e_rst);
      chk(string'(VECS[i].tag), "wp", wp, VECS[i].e_wp);
      chk(string'(VECS[i].tag), "bkup", bkup, VECS[i].e_bkup);
      if (!rst_no) chk("R5", "wp under reset", wp, 1'b1);
    end

    // R2: exact fall edge
    set_flags(3'b011);
    tick(2);
    chk("R2", "rst_no after 2 edges", rst_no, 1'b1);
    tick(1);
    chk("R2", "rst_no after 3 edges", rst_no, 1'b0);
    chk("R5", "wp with reset", wp, 1'b1);

    // R3: exact release edge
    tick(10);
    set_flags(3'b111);
    tick(HOLD + 1);
    chk("R3", "rst_no before hold end", rst_no, 1'b0);
    chk("R5", "wp during hold", wp, 1'b1);
    tick(1);
    chk("R3", "rst_no at hold end", rst_no, 1'b1);
    chk("R3", "wp at hold end", wp, 1'b0);

    // R9: stays released
    begin
      bit stayed = 1'b1;
      for (int k = 0; k < 200; k++) begin
        tick(1);
        if (!rst_no) stayed = 1'b0;
      end
      chk("R9", "rst_no steady", stayed, 1'b1);
    end

    // R4: one-edge dip restarts the hold
    set_flags(3'b011);
    tick(10);
    set_flags(3'b111);
    tick(8);
    set_flags(3'b011);
    tick(1);
    set_flags(3'b111);
    tick(HOLD + 1);
    chk("R4", "rst_no before restarted hold end", rst_no, 1'b0);
    tick(1);
    chk("R4", "rst_no at restarted hold end", rst_no, 1'b1);

    // R6: protect drop, exact edge, held until release
    set_flags(3'b101);
    tick(2);
    chk("R6", "wp after 2 edges", wp, 1'b0);
    tick(1);
    chk("R6", "wp after 3 edges", wp, 1'b1);
    set_flags(3'b111);
    tick(HOLD);
    chk("R6", "wp held during hold", wp, 1'b1);
    tick(5);
    chk("R6", "wp cleared after release", wp, 1'b0);

    // R7: backup select latency both ways
    set_flags(3'b110);
    tick(2);
    chk("R7", "bkup after 2 edges", bkup, 1'b0);
    tick(1);
    chk("R7", "bkup after 3 edges", bkup, 1'b1);
    set_flags(3'b111);
    tick(2);
    chk("R7", "bkup back after 2 edges", bkup, 1'b1);
    tick(1);
    chk("R7", "bkup back after 3 edges", bkup, 1'b0);
    chk("R8", "rst_no still held after backup", rst_no, 1'b0);

    tick(30);
    chk("R3", "final release", rst_no, 1'b1);
    finish_run();
  end
endmodule